// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block is one 8-bit output port that a host fills one byte at a time and an external device drains under a two-wire handshake. When the host writes a byte to the data address, the byte is registered onto the port pins. At the same time the active-low buffer-full line drops to tell the device that a byte is waiting. The device answers with an active-low acknowledge pulse. The falling edge of acknowledge releases buffer-full. The rising edge raises an interrupt request, provided the interrupt enable is set, so that the host can supply the next byte.

The interrupt enable has no address of its own. The host sets or clears it with a single-bit set/reset command word written to the control address. The same command form drives two spare general-purpose output lines that the handshake leaves free. Acknowledge comes from outside the clock domain, so it passes through a synchronizer before its edges are detected. A parameter chooses which command bit number is the enable: 6 in the default port-A variant, 2 in the port-B variant.

Top module: `strobed_out_port`

## Requirements
- R1: A host write (`cs`=1, `wr`=1, `addr`=0) puts `wdata` on `pd_out` after the next clock edge. `pd_out` then keeps that value until the next such write, whatever `ack_n` does.
- R2: `obf_n` is 0 after the clock edge that takes a data write.
- R3: A falling edge on `ack_n` sets `obf_n` to 1 on the third clock edge after `ack_n` is first sampled low. If a data write lands on that same edge, the write wins and `obf_n` stays 0.
- R4: A control write (`addr`=3, `wdata[7]`=0) is a bit command. `wdata[3:1]` is the bit number and `wdata[0]` is the value. Bit number 6 (or 2 in the port-B variant) writes the interrupt enable.
- R5: A rising edge on `ack_n` sets `intr` to 1 on the third clock edge after `ack_n` is first sampled high, but only if `obf_n` is 1 and the enable is 1 at that edge. Otherwise `intr` stays 0.
- R6: `intr` returns to 0 on the edge that takes a data write. It also returns to 0 on the edge that takes a bit command clearing the enable.
- R7: Bit commands for bit number 4 and bit number 5 drive `gp_out[0]` and `gp_out[1]`. Bit commands for any other bit number leave `gp_out`, `obf_n` and `intr` unchanged.
- R8: The following writes have no effect on any output or on the enable: a control word with `wdata[7]`=1, a write to address 1 or 2, and any cycle with `cs`=0 or `wr`=0.
- R9: Synchronous reset sets `pd_out` to 0, `obf_n` to 1, `intr` to 0, the enable to 0 and `gp_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Host select |
| wr | input | 1 | Host write strobe, one cycle per write |
| addr | input | 2 | Host address: 0 data, 3 control |
| wdata | input | 8 | Host write data |
| ack_n | input | 1 | Acknowledge from device, active low, asynchronous |
| pd_out | output | 8 | Latched port data |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request to host |
| gp_out | output | 2 | Spare lines set by bit commands 5 and 4 |

## Verification
The handshake is tried with several sequences:
- Write then acknowledge, with the enable set. This separates the buffer-full release on the falling edge from the interrupt on the rising edge.
- The same sequence with the enable cleared, and an acknowledge arriving while nothing is pending. These show whether the interrupt is gated by the enable and by the buffer-full state.
- Back-to-back writes with no acknowledge between them.
- A write timed onto the same edge as a detected acknowledge fall. This checks the priority between the two.

Command words at neighbouring bit numbers, mode-flagged words and writes to unused addresses check that only the intended bit changes.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned BSR_IDX_W = 3;

  // Command bit number that holds the interrupt enable for each port variant.
  function automatic int unsigned inte_index(input bit port_b);
    return port_b ? 2 : 6;
  endfunction
endpackage

// File: rtl/sop_ack_sync.sv
module sop_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  output logic ack_fall,
  output logic ack_rise
);
  localparam int unsigned LAST = STAGES;

  // sh[STAGES-1] is the synchronized level; sh[STAGES] is its previous value.
  logic [LAST:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[LAST-1:0], ack_n};
  end

  assign ack_fall = sh[LAST] & ~sh[LAST-1];
  assign ack_rise = ~sh[LAST] & sh[LAST-1];
endmodule

// File: rtl/sop_host_decode.sv
module sop_host_decode
  import sop_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned AW        = 2,
  parameter int unsigned DATA_ADDR = 0,
  parameter int unsigned CTRL_ADDR = 3
) (
  input  logic                 cs,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic                 data_we,
  output logic [DW-1:0]        data,
  output logic                 bsr_we,
  output logic [BSR_IDX_W-1:0] bsr_idx,
  output logic                 bsr_val
);
  logic hit;

  assign hit     = cs & wr;
  assign data_we = hit && (addr == AW'(DATA_ADDR));
  // A control word with the top bit clear is a single-bit command; a word with
  // the top bit set would select a port mode and is ignored here.
  assign bsr_we  = hit && (addr == AW'(CTRL_ADDR)) && !wdata[DW-1];
  assign bsr_idx = wdata[BSR_IDX_W:1];
  assign bsr_val = wdata[0];
  assign data    = wdata;
endmodule

// File: rtl/sop_hs_core.sv
module sop_hs_core
  import sop_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned INTE_IDX = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 data_we,
  input  logic [DW-1:0]        data,
  input  logic                 bsr_we,
  input  logic [BSR_IDX_W-1:0] bsr_idx,
  input  logic                 bsr_val,
  input  logic                 ack_fall,
  input  logic                 ack_rise,
  output logic [DW-1:0]        pd_out,
  output logic                 obf_n,
  output logic                 intr
);
  logic inte;
  logic inte_hit;

  assign inte_hit = bsr_we && (bsr_idx == BSR_IDX_W'(INTE_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_out <= '0;
      obf_n  <= 1'b1;
      intr   <= 1'b0;
      inte   <= 1'b0;
    end else begin
      if (inte_hit) inte <= bsr_val;
      if (data_we) begin
        pd_out <= data;
        obf_n  <= 1'b0;
        intr   <= 1'b0;
      end else begin
        if (ack_fall) obf_n <= 1'b1;
        if (inte_hit && !bsr_val)            intr <= 1'b0;
        else if (ack_rise && obf_n && inte)  intr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sop_gp_bits.sv
module sop_gp_bits
  import sop_pkg::*;
#(
  parameter int unsigned COUNT = 2,
  parameter int unsigned BASE  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bsr_we,
  input  logic [BSR_IDX_W-1:0] bsr_idx,
  input  logic                 bsr_val,
  output logic [COUNT-1:0]     gp_out
);
  for (genvar i = 0; i < COUNT; i++) begin : g_line
    localparam int unsigned IDX = BASE + i;
    always_ff @(posedge clk) begin
      if (rst) gp_out[i] <= 1'b0;
      else if (bsr_we && bsr_idx == BSR_IDX_W'(IDX)) gp_out[i] <= bsr_val;
    end
  end
endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port
  import sop_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 2,
  parameter bit          PORT_B      = 1'b0,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GP_COUNT    = 2,
  parameter int unsigned GP_BASE     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs,
  input  logic                wr,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic                ack_n,
  output logic [DW-1:0]       pd_out,
  output logic                obf_n,
  output logic                intr,
  output logic [GP_COUNT-1:0] gp_out
);
  localparam int unsigned INTE_IDX = inte_index(PORT_B);

  logic                 data_we;
  logic [DW-1:0]        data;
  logic                 bsr_we;
  logic [BSR_IDX_W-1:0] bsr_idx;
  logic                 bsr_val;
  logic                 ack_fall;
  logic                 ack_rise;

  sop_host_decode #(.DW(DW), .AW(AW), .DATA_ADDR(0), .CTRL_ADDR(3)) u_dec (
    .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
    .data_we(data_we), .data(data),
    .bsr_we(bsr_we), .bsr_idx(bsr_idx), .bsr_val(bsr_val)
  );

  sop_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ack_n(ack_n),
    .ack_fall(ack_fall), .ack_rise(ack_rise)
  );

  sop_hs_core #(.DW(DW), .INTE_IDX(INTE_IDX)) u_core (
    .clk(clk), .rst(rst),
    .data_we(data_we), .data(data),
    .bsr_we(bsr_we), .bsr_idx(bsr_idx), .bsr_val(bsr_val),
    .ack_fall(ack_fall), .ack_rise(ack_rise),
    .pd_out(pd_out), .obf_n(obf_n), .intr(intr)
  );

  sop_gp_bits #(.COUNT(GP_COUNT), .BASE(GP_BASE)) u_gp (
    .clk(clk), .rst(rst),
    .bsr_we(bsr_we), .bsr_idx(bsr_idx), .bsr_val(bsr_val),
    .gp_out(gp_out)
  );
endmodule

// File: rtl/sop_checker.sv
module sop_checker #(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 2,
  parameter int unsigned GP_COUNT = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                cs,
  input logic                wr,
  input logic [AW-1:0]       addr,
  input logic [DW-1:0]       wdata,
  input logic [DW-1:0]       pd_out,
  input logic                obf_n,
  input logic                intr,
  input logic [GP_COUNT-1:0] gp_out
);
  logic dwr;
  assign dwr = cs && wr && (addr == '0);

  // R1: written byte appears next cycle
  p_data_latched_r1: assert property (@(posedge clk) disable iff (rst)
    dwr |=> pd_out == $past(wdata));
  // R1: port data holds without a data write
  p_data_holds_r1: assert property (@(posedge clk) disable iff (rst)
    !dwr |=> $stable(pd_out));
  // R2: buffer-full asserted after a write
  p_obf_low_r2: assert property (@(posedge clk) disable iff (rst)
    dwr |=> !obf_n);
  // R3: a release never happens on a write edge
  p_obf_release_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(obf_n) |-> !$past(dwr));
  // R5: interrupt only rises while buffer-full is inactive
  p_intr_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(intr) |-> obf_n);
  // R6: a data write clears the interrupt
  p_intr_clear_r6: assert property (@(posedge clk) disable iff (rst)
    dwr |=> !intr);
  // R9: reset state
  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (obf_n && !intr && pd_out == '0 && gp_out == '0));
endmodule

bind strobed_out_port sop_checker #(.DW(DW), .AW(AW), .GP_COUNT(GP_COUNT)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
  .pd_out(pd_out), .obf_n(obf_n), .intr(intr), .gp_out(gp_out)
);

// File: tb/sim_strobed_out_port.sv
module sim_strobed_out_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ack_n = 1'b1;
  logic [7:0] pd_out;
  logic       obf_n, intr;
  logic [1:0] gp_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strobed_out_port u0 (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
    .ack_n(ack_n), .pd_out(pd_out), .obf_n(obf_n), .intr(intr), .gp_out(gp_out)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_ACK = 2'd1, OP_BSR = 2'd2;
  // {op, arg, expected pd_out, expected obf_n, expected intr}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {OP_BSR, 8'h0D, 8'h00, 1'b1, 1'b0},  // R4 enable set
    {OP_WR,  8'hA5, 8'hA5, 1'b0, 1'b0},  // R1 R2
    {OP_ACK, 8'h00, 8'hA5, 1'b1, 1'b1},  // R3 R5
    {OP_WR,  8'h3C, 8'h3C, 1'b0, 1'b0},  // R6 cleared by write
    {OP_ACK, 8'h00, 8'h3C, 1'b1, 1'b1},
    {OP_BSR, 8'h0C, 8'h3C, 1'b1, 1'b0},  // R6 cleared by enable clear
    {OP_WR,  8'hFF, 8'hFF, 1'b0, 1'b0},
    {OP_ACK, 8'h00, 8'hFF, 1'b1, 1'b0},  // R5 enable off
    {OP_ACK, 8'h00, 8'hFF, 1'b1, 1'b0},
    {OP_BSR, 8'h0D, 8'hFF, 1'b1, 1'b0},
    {OP_ACK, 8'h00, 8'hFF, 1'b1, 1'b1},  // R5 nothing pending, enabled
    {OP_WR,  8'h00, 8'h00, 1'b0, 1'b0},
    {OP_WR,  8'h81, 8'h81, 1'b0, 1'b0},  // R1 back-to-back
    {OP_ACK, 8'h00, 8'h81, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host(input logic [1:0] a, input logic [7:0] d);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  // Low for four cycles, then high for three; state checked after release.
  task automatic ack_pulse();
    ack_n = 1'b0;
    repeat (4) @(negedge clk);
    ack_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 pd_out", pd_out, 0);
    chk("R9 obf_n", obf_n, 1);
    chk("R9 intr", intr, 0);
    chk("R9 gp_out", gp_out, 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][19:18])
        OP_WR:   host(2'd0, VEC[i][17:10]);
        OP_BSR:  host(2'd3, VEC[i][17:10]);
        default: ack_pulse();
      endcase
      chk($sformatf("R1 vec%0d pd_out", i), pd_out, VEC[i][9:2]);
      chk($sformatf("R2 R3 vec%0d obf_n", i), obf_n, VEC[i][1]);
      chk($sformatf("R5 R6 vec%0d intr", i), intr, VEC[i][0]);
    end

    // R3 timing: obf_n released exactly on the third edge after ack low
    host(2'd0, 8'h55);
    ack_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 obf_n before third edge", obf_n, 0);
    @(negedge clk);
    chk("R3 obf_n after third edge", obf_n, 1);
    chk("R1 data held during ack", pd_out, 8'h55);
    ack_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 collision: write on the same edge that takes the detected fall
    ack_n = 1'b0;
    repeat (2) @(negedge clk);
    host(2'd0, 8'h66);
    chk("R3 write wins over ack fall", obf_n, 0);
    @(negedge clk);
    ack_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 no intr while buffer full", intr, 0);
    chk("R1 pd_out after collision", pd_out, 8'h66);

    // R8: ignored writes
    host(2'd1, 8'h11);
    host(2'd2, 8'h22);
    cs = 1'b0; wr = 1'b1; addr = 2'd0; wdata = 8'h33;
    @(negedge clk);
    cs = 1'b1; wr = 1'b0;
    @(negedge clk);
    cs = 1'b0;
    chk("R8 pd_out unchanged", pd_out, 8'h66);
    chk("R8 obf_n unchanged", obf_n, 0);
    host(2'd3, 8'h0C);               // clear enable
    host(2'd3, 8'h8D);               // mode-flagged word, must not set enable
    host(2'd3, 8'h8B);               // mode-flagged word, must not set gp line
    chk("R8 gp_out unchanged by mode word", gp_out, 0);
    ack_pulse();
    chk("R8 mode word left enable clear", intr, 0);

    // R7: spare lines
    host(2'd3, 8'h0B);
    chk("R7 bit5 set", gp_out, 2'b10);
    host(2'd3, 8'h09);
    chk("R7 bit4 set", gp_out, 2'b11);
    host(2'd3, 8'h0A);
    chk("R7 bit5 clear", gp_out, 2'b01);
    host(2'd3, 8'h07);
    chk("R7 bit3 no effect gp", gp_out, 2'b01);
    chk("R7 bit3 no effect intr", intr, 0);

    // R9 mid-run reset clears enable and lines
    host(2'd3, 8'h0D);
    host(2'd0, 8'h77);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset pd_out", pd_out, 0);
    chk("R9 reset obf_n", obf_n, 1);
    chk("R9 reset gp_out", gp_out, 0);
    ack_pulse();
    chk("R9 enable cleared by reset", intr, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule